// File: doc/BRIEF.md
# Delayed-Write Register Buffer

This block sits between the execution results and the architectural register file. It lets recent register writes be taken back without copying the file. Each accepted result is parked in a small ring of slots, together with the number of the register it targets. The result is released to the register file only after a fixed holding time. By then, nothing can still ask for it to be withdrawn.

While a result waits, both read ports search the ring associatively. Each port returns the newest waiting value for the register it asks for. If nothing in the ring matches, the port returns the value the register file supplies. The release register also takes part in this search, so a value stays visible in the cycle between leaving the ring and landing in the file.

A rollback command discards writes in a single cycle. It can discard every waiting write, or one write named by the slot tag it was given plus every write issued after it. Register 0 can be treated as hardwired to zero.

Top module: `delay_wr_buf`

## Requirements
- R1: A write captured at a clock edge appears on `commit_en`, `commit_reg` and `commit_data` exactly DELAY edges later, provided it was not discarded. With DELAY=4, `commit_en` stays low for the four negedge samples after the write and is high at the fifth.
- R2: Surviving writes are released to the file one per cycle, in the order they were accepted.
- R3: A read port returns its result one edge after the register number is presented. The result comes from the newest pending write to that register. When no write to that register is pending, the result is the `rd_file_*` value.
- R4: A value that has just been released is still forwarded in its release cycle, while `commit_en` is high. Reads of that register therefore return it continuously until the file holds it.
- R5: `inv_cmd`=2'b01 with `inv_tag` naming a pending slot discards that write and every younger one. The discarded writes are never released and never forwarded. `wr_tag` then returns to `inv_tag`.
- R6: `inv_cmd`=2'b10 or 2'b11 discards every pending write in one cycle.
- R7: A write presented in the same cycle as an effective discard command is dropped, and `wr_tag` does not advance.
- R8: `inv_cmd`=2'b01 whose `inv_tag` names a slot holding no pending write has no effect. A write in that cycle is accepted.
- R9: With ZERO_REG=1, a write to register 0 is not buffered, does not advance `wr_tag` and is never released. A read of register 0 returns 0.
- R10: While reset is high, `commit_en` is 0, both read results are 0 and `wr_tag` is 0.
- R11: `wr_tag` gives the slot that the next accepted write will take. It advances by one, modulo DEPTH, for each accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Result valid this cycle |
| wr_reg | input | AW | Destination register of the result |
| wr_data | input | DW | Result value |
| wr_tag | output | $clog2(DEPTH) | Slot tag the next accepted write receives |
| inv_cmd | input | 2 | 00 none, 01 discard from tag, 1x discard all |
| inv_tag | input | $clog2(DEPTH) | Oldest slot to discard for command 01 |
| rd_reg_a | input | AW | Read port A register number |
| rd_file_a | input | DW | Register file value for `rd_reg_a` |
| rd_data_a | output | DW | Read port A result, registered |
| rd_reg_b | input | AW | Read port B register number |
| rd_file_b | input | DW | Register file value for `rd_reg_b` |
| rd_data_b | output | DW | Read port B result, registered |
| commit_en | output | 1 | Release strobe to the register file |
| commit_reg | output | AW | Register being released |
| commit_data | output | DW | Value being released |

## Verification
Several properties are checked on every cycle. No pending slot may age beyond the holding time. Pending slots must stay contiguous from the oldest. A write must always land in a free slot. A discard-all command must leave the ring empty, register 0 must never be released, and a read of register 0 must return zero. Other behaviours can only be shown by directed scenarios with known data: the exact release cycle, release order, newest-match forwarding, forwarding from the release stage, suffix discard, dropping a write during a discard, and ignoring a stale tag.

// File: rtl/dwbuf_pkg.sv
package dwbuf_pkg;
  typedef enum logic [1:0] {
    INV_NONE    = 2'b00,
    INV_SUFFIX  = 2'b01,
    INV_ALL     = 2'b10,
    INV_ALL_ALT = 2'b11
  } inv_cmd_e;
endpackage

// File: rtl/dwbuf_ctl.sv
module dwbuf_ctl import dwbuf_pkg::*; #(
  parameter int DEPTH    = 4,
  parameter int DELAY    = 4,
  parameter int AW       = 5,
  parameter int DW       = 32,
  parameter bit ZERO_REG = 1'b1,
  localparam int IW = $clog2(DEPTH),
  localparam int GW = $clog2(DELAY + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_reg,
  input  logic [DW-1:0]             wr_data,
  input  logic [1:0]                inv_cmd,
  input  logic [IW-1:0]             inv_tag,
  output logic [IW-1:0]             tail,
  output logic [IW-1:0]             head,
  output logic [DEPTH-1:0]          vld,
  output logic [DEPTH-1:0][AW-1:0]  ent_reg,
  output logic [DEPTH-1:0][DW-1:0]  ent_data,
  output logic                      cm_en,
  output logic [AW-1:0]             cm_reg,
  output logic [DW-1:0]             cm_data
);
  logic [IW-1:0]            head_q, tail_q;
  logic [DEPTH-1:0]         vld_q;
  logic [DEPTH-1:0][GW-1:0] age_q;
  logic [DEPTH-1:0][AW-1:0] reg_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic                     cm_en_q;
  logic [AW-1:0]            cm_reg_q;
  logic [DW-1:0]            cm_data_q;

  inv_cmd_e         cmd;
  logic             kill_all, kill_sfx, kill_any, fire, wr_ok;
  logic [IW-1:0]    sfx_rel;
  logic [DEPTH-1:0] kill;

  assign cmd      = inv_cmd_e'(inv_cmd);
  assign kill_all = (cmd == INV_ALL) || (cmd == INV_ALL_ALT);
  assign kill_sfx = (cmd == INV_SUFFIX) && vld_q[inv_tag];
  assign kill_any = kill_all || kill_sfx;
  assign sfx_rel  = inv_tag - head_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_kill
    logic [IW-1:0] rel;
    assign rel     = IW'(k) - head_q;
    assign kill[k] = kill_all || (kill_sfx && (rel >= sfx_rel));
  end

  assign fire  = vld_q[head_q] && (age_q[head_q] == GW'(DELAY)) && !kill[head_q];
  assign wr_ok = wr_en && !(ZERO_REG && (wr_reg == '0)) && !kill_any;

  // Control state with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cm_en_q <= 1'b0;
    end else begin
      cm_en_q <= fire;
      vld_q   <= vld_q & ~kill;
      if (fire) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= head_q + IW'(1);
      end
      if (kill_all)      tail_q <= head_q;
      else if (kill_sfx) tail_q <= inv_tag;
      if (wr_ok) begin
        vld_q[tail_q] <= 1'b1;
        tail_q        <= tail_q + IW'(1);
      end
    end
  end

  // Payload storage without reset
  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (vld_q[k]) age_q[k] <= age_q[k] + GW'(1);
    end
    if (wr_ok) begin
      age_q[tail_q]  <= GW'(1);
      reg_q[tail_q]  <= wr_reg;
      data_q[tail_q] <= wr_data;
    end
    if (fire) begin
      cm_reg_q  <= reg_q[head_q];
      cm_data_q <= data_q[head_q];
    end
  end

  assign tail     = tail_q;
  assign head     = head_q;
  assign vld      = vld_q;
  assign ent_reg  = reg_q;
  assign ent_data = data_q;
  assign cm_en    = cm_en_q;
  assign cm_reg   = cm_reg_q;
  assign cm_data  = cm_data_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_age_chk
    // R1
    age_bound_chk: assert property (@(posedge clk) disable iff (rst)
      vld_q[k] |-> (age_q[k] <= GW'(DELAY)));
  end

  // R2
  slot_free_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok |-> (!vld_q[tail_q] || (fire && (head_q == tail_q))));

  // R5
  contig_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_q[head_q] |-> (vld_q == '0));

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    kill_all |=> (vld_q == '0));

  // R9
  no_zero_commit_chk: assert property (@(posedge clk) disable iff (rst)
    cm_en_q |-> (!ZERO_REG || (cm_reg_q != '0)));

  initial begin
    // R2
    depth_cover_chk: assert (DEPTH >= DELAY && DEPTH >= 2 && (1 << IW) == DEPTH);
  end
endmodule

// File: rtl/dwbuf_fwd.sv
module dwbuf_fwd #(
  parameter int DEPTH    = 4,
  parameter int AW       = 5,
  parameter int DW       = 32,
  parameter bit ZERO_REG = 1'b1,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [IW-1:0]            head,
  input  logic [DEPTH-1:0]         vld,
  input  logic [DEPTH-1:0][AW-1:0] ent_reg,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic                     cm_en,
  input  logic [AW-1:0]            cm_reg,
  input  logic [DW-1:0]            cm_data,
  input  logic [AW-1:0]            rd_reg,
  input  logic [DW-1:0]            rd_file,
  output logic [DW-1:0]            rd_data
);
  logic [DW-1:0] pick;
  logic [DW-1:0] rd_data_q;

  // Oldest source first, so the youngest match overrides
  always_comb begin
    logic [IW-1:0] slot;
    pick = rd_file;
    if (cm_en && (cm_reg == rd_reg)) pick = cm_data;
    for (int i = 0; i < DEPTH; i++) begin
      slot = head + IW'(i);
      if (vld[slot] && (ent_reg[slot] == rd_reg)) pick = ent_data[slot];
    end
    if (ZERO_REG && (rd_reg == '0)) pick = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_q <= '0;
    else     rd_data_q <= pick;
  end

  assign rd_data = rd_data_q;

  // R9
  zero_read_chk: assert property (@(posedge clk) disable iff (rst)
    (ZERO_REG && (rd_reg == '0)) |=> (rd_data_q == '0));
endmodule

// File: rtl/delay_wr_buf.sv
module delay_wr_buf #(
  parameter int DEPTH    = 4,
  parameter int DELAY    = 4,
  parameter int AW       = 5,
  parameter int DW       = 32,
  parameter bit ZERO_REG = 1'b1,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_reg,
  input  logic [DW-1:0] wr_data,
  output logic [IW-1:0] wr_tag,
  input  logic [1:0]    inv_cmd,
  input  logic [IW-1:0] inv_tag,
  input  logic [AW-1:0] rd_reg_a,
  input  logic [DW-1:0] rd_file_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [AW-1:0] rd_reg_b,
  input  logic [DW-1:0] rd_file_b,
  output logic [DW-1:0] rd_data_b,
  output logic          commit_en,
  output logic [AW-1:0] commit_reg,
  output logic [DW-1:0] commit_data
);
  localparam int NRD = 2;

  logic [IW-1:0]            head;
  logic [DEPTH-1:0]         vld;
  logic [DEPTH-1:0][AW-1:0] ent_reg;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [NRD-1:0][AW-1:0]   rq;
  logic [NRD-1:0][DW-1:0]   rf_in, rd_out;

  dwbuf_ctl #(
    .DEPTH(DEPTH), .DELAY(DELAY), .AW(AW), .DW(DW), .ZERO_REG(ZERO_REG)
  ) u_ctl (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
    .inv_cmd(inv_cmd), .inv_tag(inv_tag),
    .tail(wr_tag), .head(head), .vld(vld),
    .ent_reg(ent_reg), .ent_data(ent_data),
    .cm_en(commit_en), .cm_reg(commit_reg), .cm_data(commit_data)
  );

  assign rq    = {rd_reg_b, rd_reg_a};
  assign rf_in = {rd_file_b, rd_file_a};

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    dwbuf_fwd #(
      .DEPTH(DEPTH), .AW(AW), .DW(DW), .ZERO_REG(ZERO_REG)
    ) u_fwd (
      .clk(clk), .rst(rst),
      .head(head), .vld(vld), .ent_reg(ent_reg), .ent_data(ent_data),
      .cm_en(commit_en), .cm_reg(commit_reg), .cm_data(commit_data),
      .rd_reg(rq[p]), .rd_file(rf_in[p]), .rd_data(rd_out[p])
    );
  end

  assign rd_data_a = rd_out[0];
  assign rd_data_b = rd_out[1];
endmodule

// File: tb/delay_wr_buf_test.sv
module delay_wr_buf_test;
  localparam int DEPTH = 4, DELAY = 4, AW = 5, DW = 32, NREG = 32;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_reg = '0;
  logic [DW-1:0] wr_data = '0;
  logic [IW-1:0] wr_tag;
  logic [1:0]    inv_cmd = 2'b00;
  logic [IW-1:0] inv_tag = '0;
  logic [AW-1:0] rd_reg_a = '0, rd_reg_b = '0;
  logic [DW-1:0] rd_file_a, rd_file_b, rd_data_a, rd_data_b;
  logic          commit_en;
  logic [AW-1:0] commit_reg;
  logic [DW-1:0] commit_data;

  delay_wr_buf #(.DEPTH(DEPTH), .DELAY(DELAY), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data), .wr_tag(wr_tag),
    .inv_cmd(inv_cmd), .inv_tag(inv_tag),
    .rd_reg_a(rd_reg_a), .rd_file_a(rd_file_a), .rd_data_a(rd_data_a),
    .rd_reg_b(rd_reg_b), .rd_file_b(rd_file_b), .rd_data_b(rd_data_b),
    .commit_en(commit_en), .commit_reg(commit_reg), .commit_data(commit_data)
  );

  // Register file model, written at the edge where commit_en is high
  logic [DW-1:0] rf [NREG];
  int            ncommit = 0;
  logic [AW-1:0] c_reg [64];
  logic [DW-1:0] c_dat [64];

  assign rd_file_a = rf[rd_reg_a];
  assign rd_file_b = rf[rd_reg_b];

  always @(posedge clk) begin
    if (!rst && commit_en) begin
      rf[commit_reg] <= commit_data;
      if (ncommit < 64) begin
        c_reg[ncommit] <= commit_reg;
        c_dat[ncommit] <= commit_data;
      end
      ncommit <= ncommit + 1;
    end
  end

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en   = 1'b0;
    inv_cmd = 2'b00;
  endtask

  task automatic put(input logic [AW-1:0] r, input logic [DW-1:0] d);
    wr_en   = 1'b1;
    wr_reg  = r;
    wr_data = d;
  endtask

  task automatic drain();
    idle();
    repeat (DELAY + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 commit_en in reset", commit_en, 0);
    check("R10 rd_data_a in reset", rd_data_a, 0);
    check("R10 rd_data_b in reset", rd_data_b, 0);
    check("R10 wr_tag in reset", wr_tag, 0);
  endtask

  task automatic t_delay();
    logic [IW-1:0] t0;
    t0 = wr_tag;
    put(5, 32'hA5A5_0001);
    for (int i = 1; i <= DELAY; i++) begin
      @(negedge clk);
      if (i == 1) begin
        idle();
        check("R11 tag advance", wr_tag, IW'(t0 + 1));
      end
      check("R1 no early commit", commit_en, 0);
    end
    @(negedge clk);
    check("R1 commit_en on time", commit_en, 1);
    check("R1 commit_reg", commit_reg, 5);
    check("R1 commit_data", commit_data, 32'hA5A5_0001);
    drain();
  endtask

  task automatic t_forward();
    int c0;
    c0 = ncommit;
    put(3, 32'd11); @(negedge clk);
    put(3, 32'd22); @(negedge clk);
    put(7, 32'd99); @(negedge clk);
    idle(); rd_reg_a = 3; rd_reg_b = 7;
    @(negedge clk);
    check("R3 youngest of two r3", rd_data_a, 22);
    check("R3 forward r7", rd_data_b, 99);
    rd_reg_a = 4; rd_reg_b = 3;
    @(negedge clk);
    check("R3 no match gives file", rd_data_a, 32'h1004);
    check("R3 second port youngest", rd_data_b, 22);
    drain();
    check("R2 commit count", ncommit - c0, 3);
    check("R2 order first reg", c_reg[c0], 3);
    check("R2 order first data", c_dat[c0], 11);
    check("R2 order second data", c_dat[c0+1], 22);
    check("R2 order third reg", c_reg[c0+2], 7);
    check("R3 file after commit", rd_data_b, 22);
  endtask

  task automatic t_commit_fwd();
    put(9, 32'h0000_0055);
    @(negedge clk);
    idle(); rd_reg_a = 9;
    for (int i = 2; i <= DELAY + 4; i++) begin
      @(negedge clk);
      check("R4 value held through release", rd_data_a, 32'h55);
    end
    drain();
  endtask

  task automatic t_suffix();
    logic [IW-1:0] t1;
    int c0;
    c0 = ncommit;
    put(10, 32'hB0); @(negedge clk);
    t1 = wr_tag;
    put(11, 32'hB1); @(negedge clk);
    put(12, 32'hB2); @(negedge clk);
    idle(); inv_cmd = 2'b01; inv_tag = t1;
    @(negedge clk);
    idle();
    check("R5 tag rewinds", wr_tag, t1);
    rd_reg_a = 11; rd_reg_b = 12;
    @(negedge clk);
    check("R5 discarded not forwarded a", rd_data_a, 32'h100B);
    check("R5 discarded not forwarded b", rd_data_b, 32'h100C);
    drain();
    check("R5 only older commits", ncommit - c0, 1);
    check("R5 surviving reg", c_reg[c0], 10);
  endtask

  task automatic t_same_cycle();
    logic [IW-1:0] tb;
    int c0;
    c0 = ncommit;
    put(14, 32'hC4); @(negedge clk);
    tb = wr_tag;
    put(15, 32'hC5); @(negedge clk);
    put(16, 32'hC6); inv_cmd = 2'b01; inv_tag = tb;
    @(negedge clk);
    idle();
    check("R7 write dropped tag", wr_tag, tb);
    rd_reg_a = 16; rd_reg_b = 15;
    @(negedge clk);
    check("R7 dropped write invisible", rd_data_a, 32'h1010);
    check("R5 cleared write invisible", rd_data_b, 32'h100F);
    drain();
    check("R7 only oldest commits", ncommit - c0, 1);
    check("R7 surviving reg", c_reg[c0], 14);
  endtask

  task automatic t_all();
    int c0;
    c0 = ncommit;
    put(20, 32'hD0); @(negedge clk);
    put(21, 32'hD1); @(negedge clk);
    idle(); inv_cmd = 2'b10;
    @(negedge clk);
    idle(); rd_reg_a = 20; rd_reg_b = 21;
    put(22, 32'hD2); @(negedge clk);
    put(18, 32'hD8); inv_cmd = 2'b11;
    @(negedge clk);
    idle();
    check("R6 r20 gone", rd_data_a, 32'h1014);
    check("R6 r21 gone", rd_data_b, 32'h1015);
    drain();
    check("R6 nothing commits", ncommit - c0, 0);
    rd_reg_a = 18;
    @(negedge clk);
    @(negedge clk);
    check("R7 write with discard-all dropped", rd_data_a, 32'h1012);
  endtask

  task automatic t_stale();
    logic [IW-1:0] ta;
    int c0;
    ta = wr_tag;
    put(23, 32'hE3); @(negedge clk);
    drain();
    c0 = ncommit;
    put(24, 32'hE4); @(negedge clk);
    put(25, 32'hE5); inv_cmd = 2'b01; inv_tag = ta;
    @(negedge clk);
    idle();
    check("R8 write accepted", wr_tag, IW'(ta + 3));
    drain();
    check("R8 both commit", ncommit - c0, 2);
    check("R8 first reg", c_reg[c0], 24);
    check("R8 second reg", c_reg[c0+1], 25);
  endtask

  task automatic t_zero();
    logic [IW-1:0] t0;
    int c0;
    c0 = ncommit;
    t0 = wr_tag;
    put(0, 32'hDEAD_BEEF);
    @(negedge clk);
    idle(); rd_reg_a = 0;
    check("R9 tag unchanged", wr_tag, t0);
    @(negedge clk);
    check("R9 read zero", rd_data_a, 0);
    drain();
    check("R9 no commit", ncommit - c0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) rf[i] = (i == 0) ? '0 : DW'(32'h1000 + i);
    repeat (3) @(posedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_delay();
    t_forward();
    t_commit_fwd();
    t_suffix();
    t_same_cycle();
    t_all();
    t_stale();
    t_zero();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end
endmodule